// File: doc/BRIEF.md
# Interleaved ECC page reader for NAND flash

This block fetches one flash page by way of an external command sequencer and a byte-read port. The page is split into equal chunks. After a single page-open command at column 0, the block works through the chunks in order. For each one it issues a random-output jump to the chunk's data column and streams the chunk bytes out. It then issues a second jump into the spare area and captures that chunk's ECC bytes into a contiguous buffer. Once every chunk and its ECC bytes are in hand, it runs a correction phase. This phase strobes each chunk index together with its ECC slot to a downstream corrector, one chunk per cycle, and takes no status back.

A second mode checks whether a block is marked bad. It opens page 0 of the block at the marker column in the spare area, reads a single unit and flags the block as bad when the value is not erased. On a 16-bit bus the marker column is given in words and the whole word is compared. Each operation ends with a one-cycle done pulse. A request that arrives while an operation is running is dropped and reported with an error pulse.

Top module: `nand_chunk_reader`

## Requirements
- R1: After reset busy_o, done_o, err_o, bad_o, cmd_valid_o, rd_req_o, data_valid_o and corr_valid_o are all low.
- R2: A page read (bb_mode_i=0) starts with exactly one command of op 0 (page open) at column 0 and row block_i*2^PG_W + page_i. Every later command of that read has op 1 (random output).
- R3: For chunk i, the block issues an op-1 command at column i*CHUNK_BYTES and then takes CHUNK_BYTES reads. It presents each one on data_o (the low 8 bits of rd_data_i) with data_valid_o high and data_chunk_o=i, in the cycle after the read is accepted.
- R4: After the data of chunk i, the block issues an op-1 command at column PAGE_BYTES+ECC_OFF+i*ECC_BYTES and takes ECC_BYTES reads. Byte k is stored in ecc_o bits [8*(i*ECC_BYTES+k) +: 8].
- R5: Spare-area reads never raise data_valid_o. A page read raises it exactly PAGE_BYTES times.
- R6: The correction phase starts only after the last ECC byte has been read. corr_valid_o is then high for PAGE_BYTES/CHUNK_BYTES consecutive cycles, with corr_idx_o counting 0 upward and corr_ecc_o equal to that chunk's slot of ecc_o.
- R7: done_o is high for exactly one cycle per accepted request, with busy_o still high. busy_o falls in the following cycle.
- R8: A bad-block check (bb_mode_i=1, wide_i=0) issues one op-0 command at row block_i*2^PG_W and column PAGE_BYTES+BB_POS, then one read. bad_o is set at done when rd_data_i[7:0] is not 0xFF, ignoring the upper byte. A page read clears bad_o.
- R9: With wide_i=1 the marker column is (PAGE_BYTES+BB_POS)/2, and bad_o is set when the full 16-bit word is not 0xFFFF.
- R10: While busy_o is high, req_i is ignored and err_o pulses in the next cycle. The running operation's commands, data and ECC are unaffected.
- R11: cmd_valid_o stays high with op, column and row unchanged until cmd_ready_i is seen. cmd_valid_o and rd_req_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, sampled while idle |
| bb_mode_i | input | 1 | 1 selects bad-block check, 0 page read |
| wide_i | input | 1 | 16-bit bus for marker check |
| block_i | input | BLK_W | Block number |
| page_i | input | PG_W | Page within block |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Pulse: request dropped while busy |
| bad_o | output | 1 | Bad-block result, valid from done |
| cmd_valid_o | output | 1 | Command request to sequencer |
| cmd_ready_i | input | 1 | Sequencer accepts command |
| cmd_op_o | output | 1 | 0 page open, 1 random output |
| cmd_col_o | output | COL_W | Column address |
| cmd_row_o | output | ROW_W | Row address |
| rd_req_o | output | 1 | Read request to byte port |
| rd_valid_i | input | 1 | Read data returned this cycle |
| rd_data_i | input | 16 | Read data |
| data_valid_o | output | 1 | Chunk data byte valid |
| data_o | output | 8 | Chunk data byte |
| data_chunk_o | output | CH_W | Chunk of current data byte |
| ecc_o | output | 8*N_CHUNK*ECC_BYTES | Collected ECC bytes |
| corr_valid_o | output | 1 | Correction strobe |
| corr_idx_o | output | CH_W | Chunk being corrected |
| corr_ecc_o | output | 8*ECC_BYTES | ECC slot of that chunk |

## Verification
A wrong column counter shows up within one command as a jump to the wrong column. That jump makes every later streamed byte or captured ECC byte disagree with the column-dependent memory pattern of the bench. A wrong chunk or byte counter ends a chunk early or late, which shows at once as an extra or missing data_valid_o count and a shifted ECC slot. A state machine that skips or reorders phases shows in the recorded command list or in the correction strobes no later than the done pulse. Bad-marker errors show in bad_o at done, and the narrow/wide cases with differing upper bytes separate the two compare widths.

// File: rtl/nprd_pkg.sv
package nprd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_OPEN, ST_JDATA, ST_RDATA, ST_JSPARE, ST_RSPARE,
    ST_CORR, ST_BBCMD, ST_BBRD, ST_FIN
  } rd_state_e;

  typedef enum logic {
    OP_OPEN   = 1'b0,
    OP_RNDOUT = 1'b1
  } cmd_op_e;
endpackage

// File: rtl/nprd_pos_gen.sv
module nprd_pos_gen #(
  parameter int COL_W       = 10,
  parameter int CHUNK_BYTES = 128,
  parameter int ECC_BYTES   = 3,
  parameter int SPARE_START = 514
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [COL_W-1:0] data_col_o,
  output logic [COL_W-1:0] spare_col_o
);
  logic [COL_W-1:0] data_q, spare_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      spare_q <= COL_W'(SPARE_START);
    end else if (clr_i) begin
      data_q  <= '0;
      spare_q <= COL_W'(SPARE_START);
    end else if (adv_i) begin
      data_q  <= data_q + COL_W'(CHUNK_BYTES);
      spare_q <= spare_q + COL_W'(ECC_BYTES);
    end
  end

  assign data_col_o  = data_q;
  assign spare_col_o = spare_q;
endmodule

// File: rtl/nprd_ecc_buf.sv
module nprd_ecc_buf #(
  parameter int N_CHUNK   = 4,
  parameter int ECC_BYTES = 3,
  parameter int CH_W      = 2,
  parameter int CNT_W     = 7,
  localparam int TOTAL    = N_CHUNK * ECC_BYTES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_en_i,
  input  logic [CH_W-1:0]        wr_chunk_i,
  input  logic [CNT_W-1:0]       wr_byte_i,
  input  logic [7:0]             wr_data_i,
  input  logic [CH_W-1:0]        rd_chunk_i,
  output logic [8*TOTAL-1:0]     ecc_o,
  output logic [8*ECC_BYTES-1:0] rd_slot_o
);
  int wr_idx;
  always_comb wr_idx = int'(wr_chunk_i) * ECC_BYTES + int'(wr_byte_i);

  for (genvar s = 0; s < TOTAL; s++) begin : g_slot
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      b_q <= '0;
      else if (clr_i)                   b_q <= '0;
      else if (wr_en_i && wr_idx == s)  b_q <= wr_data_i;
    end
    assign ecc_o[8*s +: 8] = b_q;
  end

  assign rd_slot_o = ecc_o[8*ECC_BYTES*int'(rd_chunk_i) +: 8*ECC_BYTES];
endmodule

// File: rtl/nprd_marker_chk.sv
module nprd_marker_chk (
  input  logic        wide_i,
  input  logic [15:0] word_i,
  output logic        bad_o
);
  // erased marker reads all ones; narrow bus looks at low byte only
  always_comb begin
    if (wide_i) bad_o = (word_i != 16'hFFFF);
    else        bad_o = (word_i[7:0] != 8'hFF);
  end
endmodule

// File: rtl/nand_chunk_reader.sv
module nand_chunk_reader
  import nprd_pkg::*;
#(
  parameter int PAGE_BYTES  = 512,
  parameter int CHUNK_BYTES = 128,
  parameter int ECC_BYTES   = 3,
  parameter int ECC_OFF     = 2,
  parameter int SPARE_BYTES = 16,
  parameter int BB_POS      = 0,
  parameter int BLK_W       = 10,
  parameter int PG_W        = 6,
  localparam int N_CHUNK    = PAGE_BYTES / CHUNK_BYTES,
  localparam int CH_W       = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1,
  localparam int CNT_W      = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1,
  localparam int COL_W      = $clog2(PAGE_BYTES + SPARE_BYTES),
  localparam int ROW_W      = BLK_W + PG_W,
  localparam int ECC_W      = 8 * N_CHUNK * ECC_BYTES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   bb_mode_i,
  input  logic                   wide_i,
  input  logic [BLK_W-1:0]       block_i,
  input  logic [PG_W-1:0]        page_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic                   bad_o,
  output logic                   cmd_valid_o,
  input  logic                   cmd_ready_i,
  output logic                   cmd_op_o,
  output logic [COL_W-1:0]       cmd_col_o,
  output logic [ROW_W-1:0]       cmd_row_o,
  output logic                   rd_req_o,
  input  logic                   rd_valid_i,
  input  logic [15:0]            rd_data_i,
  output logic                   data_valid_o,
  output logic [7:0]             data_o,
  output logic [CH_W-1:0]        data_chunk_o,
  output logic [ECC_W-1:0]       ecc_o,
  output logic                   corr_valid_o,
  output logic [CH_W-1:0]        corr_idx_o,
  output logic [8*ECC_BYTES-1:0] corr_ecc_o
);
  localparam int SPARE_START = PAGE_BYTES + ECC_OFF;
  localparam int MARK_COL    = PAGE_BYTES + BB_POS;

  rd_state_e         state_q;
  logic [BLK_W-1:0]  blk_q;
  logic [PG_W-1:0]   pg_q;
  logic              wide_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CH_W-1:0]   chunk_q;
  logic [CH_W-1:0]   corr_q;
  logic              bad_q, err_q;
  logic              dv_q;
  logic [7:0]        dat_q;
  logic [CH_W-1:0]   dchunk_q;

  logic              start, last_data, last_spare, ecc_wr, mark_bad;
  logic [COL_W-1:0]  data_col, spare_col;

  assign start      = (state_q == ST_IDLE) && req_i;
  assign last_data  = (cnt_q == CNT_W'(CHUNK_BYTES - 1));
  assign last_spare = (cnt_q == CNT_W'(ECC_BYTES - 1));
  assign ecc_wr     = (state_q == ST_RSPARE) && rd_valid_i;

  nprd_pos_gen #(
    .COL_W(COL_W), .CHUNK_BYTES(CHUNK_BYTES),
    .ECC_BYTES(ECC_BYTES), .SPARE_START(SPARE_START)
  ) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(start), .adv_i(ecc_wr && last_spare),
    .data_col_o(data_col), .spare_col_o(spare_col)
  );

  nprd_ecc_buf #(
    .N_CHUNK(N_CHUNK), .ECC_BYTES(ECC_BYTES), .CH_W(CH_W), .CNT_W(CNT_W)
  ) u_ecc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(start && !bb_mode_i), .wr_en_i(ecc_wr),
    .wr_chunk_i(chunk_q), .wr_byte_i(cnt_q), .wr_data_i(rd_data_i[7:0]),
    .rd_chunk_i(corr_q), .ecc_o(ecc_o), .rd_slot_o(corr_ecc_o)
  );

  nprd_marker_chk u_mark (
    .wide_i(wide_q), .word_i(rd_data_i), .bad_o(mark_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      blk_q    <= '0;
      pg_q     <= '0;
      wide_q   <= 1'b0;
      cnt_q    <= '0;
      chunk_q  <= '0;
      corr_q   <= '0;
      bad_q    <= 1'b0;
      err_q    <= 1'b0;
      dv_q     <= 1'b0;
      dat_q    <= '0;
      dchunk_q <= '0;
    end else begin
      err_q <= req_i && (state_q != ST_IDLE);
      dv_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          blk_q   <= block_i;
          pg_q    <= bb_mode_i ? '0 : page_i;
          wide_q  <= wide_i;
          chunk_q <= '0;
          corr_q  <= '0;
          bad_q   <= 1'b0;
          state_q <= bb_mode_i ? ST_BBCMD : ST_OPEN;
        end
        ST_OPEN: if (cmd_ready_i) state_q <= ST_JDATA;
        ST_JDATA: if (cmd_ready_i) begin
          cnt_q   <= '0;
          state_q <= ST_RDATA;
        end
        ST_RDATA: if (rd_valid_i) begin
          dv_q     <= 1'b1;
          dat_q    <= rd_data_i[7:0];
          dchunk_q <= chunk_q;
          if (last_data) state_q <= ST_JSPARE;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        ST_JSPARE: if (cmd_ready_i) begin
          cnt_q   <= '0;
          state_q <= ST_RSPARE;
        end
        ST_RSPARE: if (rd_valid_i) begin
          if (!last_spare)                              cnt_q   <= cnt_q + 1'b1;
          else if (chunk_q == CH_W'(N_CHUNK - 1))       state_q <= ST_CORR;
          else begin
            chunk_q <= chunk_q + 1'b1;
            state_q <= ST_JDATA;
          end
        end
        ST_CORR: begin
          // one chunk per cycle, no status returned
          if (corr_q == CH_W'(N_CHUNK - 1)) state_q <= ST_FIN;
          else                              corr_q  <= corr_q + 1'b1;
        end
        ST_BBCMD: if (cmd_ready_i) state_q <= ST_BBRD;
        ST_BBRD: if (rd_valid_i) begin
          bad_q   <= mark_bad;
          state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_op_o    = OP_RNDOUT;
    cmd_col_o   = '0;
    unique case (state_q)
      ST_OPEN: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_OPEN;
      end
      ST_JDATA: begin
        cmd_valid_o = 1'b1;
        cmd_col_o   = data_col;
      end
      ST_JSPARE: begin
        cmd_valid_o = 1'b1;
        cmd_col_o   = spare_col;
      end
      ST_BBCMD: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_OPEN;
        cmd_col_o   = wide_q ? COL_W'(MARK_COL / 2) : COL_W'(MARK_COL);
      end
      default: ;
    endcase
  end

  assign cmd_row_o    = {blk_q, pg_q};
  assign rd_req_o     = (state_q == ST_RDATA) || (state_q == ST_RSPARE) ||
                        (state_q == ST_BBRD);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign err_o        = err_q;
  assign bad_o        = bad_q;
  assign data_valid_o = dv_q;
  assign data_o       = dat_q;
  assign data_chunk_o = dchunk_q;
  assign corr_valid_o = (state_q == ST_CORR);
  assign corr_idx_o   = corr_q;
endmodule

// File: rtl/nprd_chk.sv
module nprd_chk #(
  parameter int COL_W = 10,
  parameter int ROW_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic             cmd_op_o,
  input logic [COL_W-1:0] cmd_col_o,
  input logic [ROW_W-1:0] cmd_row_o,
  input logic             rd_req_o,
  input logic             rd_valid_i,
  input logic             data_valid_o,
  input logic             corr_valid_o
);
  a_r11_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) &&
    $stable(cmd_col_o) && $stable(cmd_row_o));

  a_r11_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && rd_req_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r7_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r10_err_on_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && busy_o |=> err_o);

  a_r3_data_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(rd_req_o && rd_valid_i));

  a_r6_corr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> busy_o && !rd_req_o && !cmd_valid_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o && !rd_req_o && !corr_valid_o);
endmodule

bind nand_chunk_reader nprd_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o), .cmd_col_o(cmd_col_o),
  .cmd_row_o(cmd_row_o), .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i),
  .data_valid_o(data_valid_o), .corr_valid_o(corr_valid_o)
);

// File: tb/nand_chunk_reader_test.sv
module nand_chunk_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE  = 512;
  localparam int CHUNK = 128;
  localparam int EB    = 3;
  localparam int EOFF  = 2;
  localparam int SPARE = 16;
  localparam int BBP   = 0;
  localparam int BLK_W = 10;
  localparam int PG_W  = 6;
  localparam int NCH   = PAGE / CHUNK;
  localparam int CH_W  = $clog2(NCH);
  localparam int COL_W = $clog2(PAGE + SPARE);
  localparam int ROW_W = BLK_W + PG_W;
  localparam int ECC_W = 8 * NCH * EB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, bbm = 1'b0, wide = 1'b0;
  logic [BLK_W-1:0] blk = '0;
  logic [PG_W-1:0] pg = '0;
  logic busy, done, err, bad, cvalid, cready = 1'b0, cop;
  logic [COL_W-1:0] ccol;
  logic [ROW_W-1:0] crow;
  logic rreq, rvalid = 1'b0;
  logic [15:0] rdata = '0;
  logic dvalid;
  logic [7:0] dat;
  logic [CH_W-1:0] dchunk, cidx;
  logic [ECC_W-1:0] ecc;
  logic corr_v;
  logic [8*EB-1:0] cecc;

  nand_chunk_reader uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .bb_mode_i(bbm), .wide_i(wide),
    .block_i(blk), .page_i(pg), .busy_o(busy), .done_o(done), .err_o(err),
    .bad_o(bad), .cmd_valid_o(cvalid), .cmd_ready_i(cready), .cmd_op_o(cop),
    .cmd_col_o(ccol), .cmd_row_o(crow), .rd_req_o(rreq), .rd_valid_i(rvalid),
    .rd_data_i(rdata), .data_valid_o(dvalid), .data_o(dat),
    .data_chunk_o(dchunk), .ecc_o(ecc), .corr_valid_o(corr_v),
    .corr_idx_o(cidx), .corr_ecc_o(cecc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int rdy_pct = 100, vld_pct = 100;
  bit bb_test = 0;
  logic [15:0] bb_word = 16'hFFFF;
  int cur_row = 0, cur_col = 0, exp_row = 0;
  int log_n = 0, seen = 0, corr_seen = 0;
  int log_op[16], log_col[16], log_row[16];

  function automatic logic [7:0] byte_of(input int row, input int col);
    return 8'((row * 29) + (col * 7) + ((col >> 8) * 101) + 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sequencer / flash model and output monitor
  always @(negedge clk) begin
    cready <= 1'b0;
    rvalid <= 1'b0;
    if (rst_n) begin
      if (cvalid && (int'($urandom % 100) < rdy_pct)) begin
        cready <= 1'b1;
        if (log_n < 16) begin
          log_op[log_n] = int'(cop); log_col[log_n] = int'(ccol); log_row[log_n] = int'(crow);
        end
        log_n++;
        cur_col = int'(ccol);
        if (cop == 1'b0) cur_row = int'(crow);
      end
      if (rreq && (int'($urandom % 100) < vld_pct)) begin
        rvalid <= 1'b1;
        if (bb_test) rdata <= bb_word;
        else rdata <= {byte_of(cur_row, cur_col) ^ 8'h5A, byte_of(cur_row, cur_col)};
        cur_col++;
      end
      if (dvalid) begin
        chk(dat == byte_of(exp_row, seen), "R3 data byte", dat, byte_of(exp_row, seen));
        chk(int'(dchunk) == seen / CHUNK, "R3 data chunk", dchunk, seen / CHUNK);
        seen++;
      end
      if (corr_v) begin
        chk(int'(cidx) == corr_seen, "R6 corr index", cidx, corr_seen);
        for (int k = 0; k < EB; k++)
          chk(cecc[8*k +: 8] == byte_of(exp_row, PAGE + EOFF + corr_seen*EB + k),
              "R6 corr slot", cecc[8*k +: 8], byte_of(exp_row, PAGE + EOFF + corr_seen*EB + k));
        chk(seen == PAGE, "R6 corr after gather", seen, PAGE);
        corr_seen++;
      end
    end
  end

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R7 done reached", done, 1);
    chk(busy == 1'b1, "R7 busy at done", busy, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7 done one cycle", {done, busy}, 0);
  endtask

  task automatic run_page(input int b, input int p, input bit poke);
    exp_row = b * (1 << PG_W) + p; log_n = 0; seen = 0; corr_seen = 0; bb_test = 0;
    @(negedge clk);
    req = 1'b1; bbm = 1'b0; blk = BLK_W'(b); pg = PG_W'(p); wide = 1'($urandom % 2);
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R7 busy after request", busy, 1);
    if (poke) begin
      repeat (25) @(negedge clk);
      req = 1'b1; bbm = 1'b1; blk = BLK_W'($urandom); pg = PG_W'($urandom);
      @(negedge clk);
      req = 1'b0;
      chk(err == 1'b1, "R10 err on busy request", err, 1);
    end
    wait_done();
    chk(seen == PAGE, "R5 data count", seen, PAGE);
    chk(corr_seen == NCH, "R6 corr count", corr_seen, NCH);
    chk(log_n == 1 + 2*NCH, "R2 command count", log_n, 1 + 2*NCH);
    chk(log_op[0] == 0 && log_col[0] == 0, "R2 open at col 0", log_col[0], 0);
    chk(log_row[0] == exp_row, "R2 open row", log_row[0], exp_row);
    for (int i = 0; i < NCH; i++) begin
      chk(log_op[1+2*i] == 1 && log_col[1+2*i] == i*CHUNK, "R3 data jump",
          log_col[1+2*i], i*CHUNK);
      chk(log_op[2+2*i] == 1 && log_col[2+2*i] == PAGE + EOFF + i*EB, "R4 spare jump",
          log_col[2+2*i], PAGE + EOFF + i*EB);
    end
    for (int j = 0; j < NCH*EB; j++)
      chk(ecc[8*j +: 8] == byte_of(exp_row, PAGE + EOFF + j), "R4 ecc slot",
          ecc[8*j +: 8], byte_of(exp_row, PAGE + EOFF + j));
    chk(bad == 1'b0, "R8 page read clears bad", bad, 0);
  endtask

  task automatic run_bb(input int b, input bit w, input logic [15:0] word, input bit exp_bad);
    int ecol;
    ecol = w ? (PAGE + BBP) / 2 : PAGE + BBP;
    exp_row = b * (1 << PG_W); log_n = 0; seen = 0; corr_seen = 0;
    bb_test = 1; bb_word = word;
    @(negedge clk);
    req = 1'b1; bbm = 1'b1; blk = BLK_W'(b); pg = PG_W'($urandom | 1); wide = w;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    chk(log_n == 1 && log_op[0] == 0, "R8 single open command", log_n, 1);
    chk(log_row[0] == exp_row, "R8 marker row", log_row[0], exp_row);
    chk(log_col[0] == ecol, w ? "R9 wide marker column" : "R8 marker column", log_col[0], ecol);
    chk(bad == exp_bad, w ? "R9 wide marker result" : "R8 narrow marker result", bad, exp_bad);
    chk(seen == 0 && corr_seen == 0, "R5 no data in check", seen, 0);
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({busy, done, err, bad, cvalid, rreq, dvalid, corr_v} == 8'h00, "R1 reset outputs",
        {busy, done, err, bad, cvalid, rreq, dvalid, corr_v}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && cvalid == 1'b0, "R1 idle after reset", {busy, cvalid}, 0);

    // directed: no stalls, first and last rows
    rdy_pct = 100; vld_pct = 100;
    run_page(0, 0, 0);
    run_page((1 << BLK_W) - 1, (1 << PG_W) - 1, 0);
    // bad-block corners, narrow and wide
    run_bb(5, 0, 16'h00FF, 0);
    run_bb(5, 0, 16'hFF7F, 1);
    run_bb(9, 1, 16'hFFFF, 0);
    run_bb(9, 1, 16'h00FF, 1);
    // page read after a bad result clears the flag
    run_page(7, 3, 0);
    // request while busy is dropped
    rdy_pct = 60; vld_pct = 70;
    run_page(12, 34, 1);
    // random stalls and addresses
    for (int n = 0; n < 4; n++) begin
      rdy_pct = 20 + int'($urandom % 80);
      vld_pct = 20 + int'($urandom % 80);
      run_page(int'($urandom % (1 << BLK_W)), int'($urandom % (1 << PG_W)), n[0]);
      run_bb(int'($urandom % (1 << BLK_W)), 1'($urandom % 2), 16'hFFFF, 0);
    end

    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule